// File: doc/BRIEF.md
# UART Receive Character Queue

This block holds characters that a UART deserializer has finished receiving until software reads them. Each stored entry is 12 bits wide: an 8-bit character in bits 7:0 and four error bits above it. Bit 8 is framing, bit 9 is parity, bit 10 is break and bit 11 is overrun. The deserializer pushes entries through a push port and watches `canAccept` to learn whether a push will be taken. A data-register read pops the oldest entry. A separate status-register write clears the error bits that were latched from the last read.

The storage is a 16-slot circular buffer. The mode input selects at run time between using all 16 slots and using a single holding register. Any change of the mode input flushes the queue. The block drives the empty and full flags and the receive-interrupt set and clear events. It also drives a status register that copies the error bits of each entry read. A line break arrives on its own input and is stored as an entry that has only the break bit set.

Top module: `rx_char_queue`

## Requirements
- R1: While reset is asserted and right after it is released, `emptyFlag` is 1, `fullFlag` is 0, `rxStatus` is 0, `rxIrqSet` and `rxIrqClr` are 0, and `canAccept` is 1 with the mode input held at 0.
- R2: With `fifoEnable` = 1, a push is taken only while fewer than 16 entries are held. With `fifoEnable` = 0, a push is taken only while nothing is held. `canAccept` reports this. A push offered while `canAccept` is 0 is dropped.
- R3: `rdEntry` always shows the slot at the read pointer. Entries come out in the order they were pushed. A push is written to the slot at (read pointer + count) mod 16, so both pointers wrap from slot 15 to slot 0.
- R4: `emptyFlag` goes to 0 on the clock edge that takes a push. It goes to 1 on the edge of a read that leaves nothing held.
- R5: `fullFlag` goes to 1 on a taken push when `fifoEnable` is 0 or when the push fills all 16 slots. Otherwise a read clears it. While `fullFlag` is 1, `canAccept` is 0.
- R6: A read of an empty queue leaves the pointer and the count unchanged. `rdEntry` keeps showing the stale content of the slot at the pointer.
- R7: On every read, bits 11:8 of `rdEntry` are copied into `rxStatus`. `statusClear` sets `rxStatus` to 0, and it wins over a read in the same cycle.
- R8: `breakPush` stores the entry 0x400, which has only the break bit (bit 10) set. It takes priority over `pushValid`.
- R9: `rxIrqSet` is 1 during a cycle whose taken push leaves the count equal to the trigger level of 1.
- R10: `rxIrqClr` is 1 during a cycle whose read, with no flush in that cycle, leaves the count at the trigger level minus one, which is 0. A read of an empty queue also raises it.
- R11: In a cycle where `fifoEnable` differs from its value at the previous edge, the queue is flushed. The count and the read pointer go to 0, `emptyFlag` goes to 1 and `fullFlag` goes to 0. A push or a read offered in that cycle is ignored, and `canAccept` is 0.
- R12: A taken push and an effective read in the same cycle leave the count unchanged and advance both pointers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifoEnable | input | 1 | 1 selects 16-slot mode, 0 selects single holding register |
| pushValid | input | 1 | Deserializer offers `pushEntry` |
| pushEntry | input | 12 | Character with error bits |
| breakPush | input | 1 | Deserializer reports a line break |
| canAccept | output | 1 | A push in this cycle will be taken |
| popRead | input | 1 | Data-register read; pops the oldest entry |
| rdEntry | output | 12 | Entry at the read pointer |
| statusClear | input | 1 | Write to the receive status register |
| rxStatus | output | 4 | Error bits latched from the last read |
| emptyFlag | output | 1 | Queue empty flag |
| fullFlag | output | 1 | Queue full flag |
| rxIrqSet | output | 1 | Receive-interrupt set event |
| rxIrqClr | output | 1 | Receive-interrupt clear event |

## Verification
The hardest state to reach from the ports is a mode change while entries are held, combined with a wrapped read pointer. In that state a flush must discard data whose slots no longer start at zero. The stimulus fills all 16 slots and drains them so that the pointer wraps. It then builds a partial backlog and toggles the mode in the same cycle as a read. A long random phase with rare mode flips and a behavioural queue model, compared on every clock, covers simultaneous push and read at every occupancy.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Strobes from the control to the datapath, one cycle wide.
  typedef struct packed {
    logic pushEn;   // write incoming entry at the write slot
    logic advance;  // move read pointer (read of a non-empty queue)
    logic latch;    // copy error bits of the entry being read
    logic flush;    // mode change: reset pointer
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TRIGGER = 1,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifoEnable,
  input  logic             pushReq,
  input  logic             popReq,
  output rxqStrobe_t       strb,
  output logic [CNT_W-1:0] count,
  output logic             canAccept,
  output logic             emptyFlag,
  output logic             fullFlag,
  output logic             rxIrqSet,
  output logic             rxIrqClr
);
  logic [CNT_W-1:0] countQ, afterPop, afterPush;
  logic fifoEnQ, flushNow, roomOk, pushEn, popEn, popDec;

  always_comb begin
    flushNow  = fifoEnable != fifoEnQ;
    roomOk    = fifoEnable ? (countQ < CNT_W'(DEPTH)) : (countQ == '0);
    canAccept = !flushNow && roomOk;
    pushEn    = pushReq && canAccept;
    popEn     = popReq && !flushNow;
    popDec    = popEn && (countQ != '0);
    afterPop  = countQ - CNT_W'(popDec);
    afterPush = afterPop + CNT_W'(pushEn);
    rxIrqSet  = pushEn && (afterPush == CNT_W'(TRIGGER));
    rxIrqClr  = popEn && (afterPop == CNT_W'(TRIGGER - 1));
    strb.pushEn  = pushEn;
    strb.advance = popDec;
    strb.latch   = popEn;
    strb.flush   = flushNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countQ    <= '0;
      fifoEnQ   <= 1'b0;
      emptyFlag <= 1'b1;
      fullFlag  <= 1'b0;
    end else begin
      fifoEnQ <= fifoEnable;
      if (flushNow) begin
        countQ    <= '0;
        emptyFlag <= 1'b1;
        fullFlag  <= 1'b0;
      end else begin
        countQ <= afterPush;
        if (pushEn)
          emptyFlag <= 1'b0;
        else if (popEn && afterPop == '0)
          emptyFlag <= 1'b1;
        if (pushEn && (!fifoEnable || afterPush == CNT_W'(DEPTH)))
          fullFlag <= 1'b1;
        else if (popEn)
          fullFlag <= 1'b0;
      end
    end
  end

  assign count = countQ;
endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 12,
  parameter int ERR_W   = 4,
  parameter int CNT_W   = $clog2(DEPTH + 1),
  parameter int PTR_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rxqStrobe_t         strb,
  input  logic [CNT_W-1:0]   count,
  input  logic [ENTRY_W-1:0] wrEntry,
  input  logic               statusClear,
  output logic [ENTRY_W-1:0] rdEntry,
  output logic [ERR_W-1:0]   rxStatus
);
  logic [ENTRY_W-1:0] slotQ [DEPTH];
  logic [PTR_W-1:0]   rdPtr, wrPtr;

  // DEPTH is a power of two, so pointer arithmetic wraps naturally.
  assign wrPtr   = rdPtr + count[PTR_W-1:0];
  assign rdEntry = slotQ[rdPtr];

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slotQ[g] <= '0;
      else if (strb.pushEn && wrPtr == PTR_W'(g))
        slotQ[g] <= wrEntry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdPtr <= '0;
    else if (strb.flush)
      rdPtr <= '0;
    else if (strb.advance)
      rdPtr <= rdPtr + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rxStatus <= '0;
    else if (statusClear)
      rxStatus <= '0;
    else if (strb.latch)
      rxStatus <= rdEntry[ENTRY_W-1 -: ERR_W];
  end
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 8,
  parameter int ERR_W   = 4,
  parameter int TRIGGER = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fifoEnable,
  input  logic                      pushValid,
  input  logic [DATA_W+ERR_W-1:0]   pushEntry,
  input  logic                      breakPush,
  output logic                      canAccept,
  input  logic                      popRead,
  output logic [DATA_W+ERR_W-1:0]   rdEntry,
  input  logic                      statusClear,
  output logic [ERR_W-1:0]          rxStatus,
  output logic                      emptyFlag,
  output logic                      fullFlag,
  output logic                      rxIrqSet,
  output logic                      rxIrqClr
);
  localparam int ENTRY_W = DATA_W + ERR_W;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int BRK_BIT = DATA_W + 2;
  localparam logic [ENTRY_W-1:0] BREAK_ENTRY = ENTRY_W'(1) << BRK_BIT;

  rxqStrobe_t       strb;
  logic [CNT_W-1:0] count;
  logic             pushReq;
  logic [ENTRY_W-1:0] wrEntry;

  assign pushReq = pushValid || breakPush;
  assign wrEntry = breakPush ? BREAK_ENTRY : pushEntry;

  rxq_ctrl #(.DEPTH(DEPTH), .TRIGGER(TRIGGER), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .fifoEnable(fifoEnable),
    .pushReq(pushReq), .popReq(popRead), .strb(strb), .count(count),
    .canAccept(canAccept), .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .rxIrqSet(rxIrqSet), .rxIrqClr(rxIrqClr)
  );

  rxq_datapath #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .ERR_W(ERR_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb), .count(count),
    .wrEntry(wrEntry), .statusClear(statusClear),
    .rdEntry(rdEntry), .rxStatus(rxStatus)
  );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
  import rxq_pkg::*;
#(
  parameter int ENTRY_W = 12,
  parameter int ERR_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fifoEnable,
  input logic               pushValid,
  input logic               breakPush,
  input logic               canAccept,
  input logic               popRead,
  input logic [ENTRY_W-1:0] rdEntry,
  input logic               statusClear,
  input logic [ERR_W-1:0]   rxStatus,
  input logic               emptyFlag,
  input logic               fullFlag,
  input logic               rxIrqSet,
  input logic               rxIrqClr,
  input rxqStrobe_t         strb
);
  // R5
  full_blocks_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fullFlag |-> !canAccept);

  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(emptyFlag && fullFlag));

  // R2
  single_slot_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifoEnable && !emptyFlag) |-> !canAccept);

  // R9
  irq_set_needs_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrqSet |-> ((pushValid || breakPush) && canAccept));

  // R9
  irq_set_leaves_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrqSet |=> !emptyFlag);

  // R10
  irq_clr_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrqClr |-> (popRead && !strb.flush));

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    statusClear |=> (rxStatus == '0));

  // R7
  status_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (popRead && !statusClear && !strb.flush)
      |=> (rxStatus == $past(rdEntry[ENTRY_W-1 -: ERR_W])));

  // R11
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flush |=> (emptyFlag && !fullFlag));

  // R11
  flush_blocks_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flush |-> !canAccept);
endmodule

bind rx_char_queue rxq_checker #(.ENTRY_W(ENTRY_W), .ERR_W(ERR_W)) uChk (
  .clk(clk), .rst_n(rst_n), .fifoEnable(fifoEnable), .pushValid(pushValid),
  .breakPush(breakPush), .canAccept(canAccept), .popRead(popRead),
  .rdEntry(rdEntry), .statusClear(statusClear), .rxStatus(rxStatus),
  .emptyFlag(emptyFlag), .fullFlag(fullFlag), .rxIrqSet(rxIrqSet),
  .rxIrqClr(rxIrqClr), .strb(strb)
);

// File: tb/tb_rx_char_queue.sv
module tb_rx_char_queue;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        fifoEnable, pushValid, breakPush, popRead, statusClear;
  logic [11:0] pushEntry;
  logic        canAccept, emptyFlag, fullFlag, rxIrqSet, rxIrqClr;
  logic [11:0] rdEntry;
  logic [3:0]  rxStatus;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural model state
  int mMem [16];
  int mCnt, mPtr, mEmp, mFul, mStat, mPrev;

  rx_char_queue dut (
    .clk(clk), .rst_n(rst_n), .fifoEnable(fifoEnable), .pushValid(pushValid),
    .pushEntry(pushEntry), .breakPush(breakPush), .canAccept(canAccept),
    .popRead(popRead), .rdEntry(rdEntry), .statusClear(statusClear),
    .rxStatus(rxStatus), .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .rxIrqSet(rxIrqSet), .rxIrqClr(rxIrqClr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mMem[i] = 0;
    mCnt = 0; mPtr = 0; mEmp = 1; mFul = 0; mStat = 0; mPrev = 0;
  endtask

  // One clock: drive, compare before the edge, advance the model after it.
  task automatic step(input bit en, input bit pv, input int pe, input bit br,
                      input bit pr, input bit sc);
    bit flush, room, acc, push, popEn, dec;
    int entry, after;
    fifoEnable = en; pushValid = pv; pushEntry = 12'(pe);
    breakPush = br; popRead = pr; statusClear = sc;
    #3;
    flush = (int'(en) != mPrev);
    room  = en ? (mCnt < 16) : (mCnt == 0);
    acc   = !flush && room;
    push  = (pv || br) && acc;
    entry = br ? 'h400 : (pe & 'hfff);
    popEn = pr && !flush;
    dec   = popEn && (mCnt > 0);
    after = mCnt - int'(dec);
    chk("R2 canAccept", int'(canAccept), int'(acc));
    chk("R3 rdEntry", int'(rdEntry), mMem[mPtr]);
    chk("R4 emptyFlag", int'(emptyFlag), mEmp);
    chk("R5 fullFlag", int'(fullFlag), mFul);
    chk("R7 rxStatus", int'(rxStatus), mStat);
    chk("R9 rxIrqSet", int'(rxIrqSet), int'(push && (after + 1 == 1)));
    chk("R10 rxIrqClr", int'(rxIrqClr), int'(popEn && (after == 0)));
    @(posedge clk);
    if (sc) mStat = 0;
    else if (popEn) mStat = (mMem[mPtr] >> 8) & 'hf;
    if (flush) begin
      mCnt = 0; mPtr = 0; mEmp = 1; mFul = 0;
    end else begin
      if (push) mMem[(mPtr + mCnt) % 16] = entry;
      if (push && (!en || after + 1 == 16)) mFul = 1;
      else if (popEn) mFul = 0;
      if (push) mEmp = 0;
      else if (popEn && after == 0) mEmp = 1;
      mCnt = after + int'(push);
      if (dec) mPtr = (mPtr + 1) % 16;
    end
    mPrev = int'(en);
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; fifoEnable = 0; pushValid = 0; pushEntry = '0;
    breakPush = 0; popRead = 0; statusClear = 0;
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 emptyFlag", int'(emptyFlag), 1);
    chk("R1 fullFlag", int'(fullFlag), 0);
    chk("R1 rxStatus", int'(rxStatus), 0);
    chk("R1 events", int'(rxIrqSet) + int'(rxIrqClr), 0);
    chk("R1 canAccept", int'(canAccept), 1);
    rst_n = 1'b1;

    // Single holding register mode (R2, R5)
    step(0, 1, 'h141, 0, 0, 0);
    step(0, 1, 'h022, 0, 0, 0);           // dropped
    chk("R2 single slot blocks", int'(canAccept), 0);
    step(0, 0, 0, 0, 1, 0);
    chk("R2 dropped push not stored", int'(emptyFlag), 1);

    // Switch to 16-slot mode: flush cycle ignores the push (R11)
    step(1, 1, 'h777, 0, 0, 0);
    chk("R11 flush keeps empty", int'(emptyFlag), 1);
    for (int i = 0; i < 17; i++)
      step(1, 1, ((i % 16) << 8) | ((i * 37) & 'hff), 0, 0, 0);
    chk("R5 full after 16", int'(fullFlag), 1);
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 1, 0);
    chk("R6 stale entry shown", int'(rdEntry), mMem[mPtr]);
    step(1, 0, 0, 0, 1, 0);               // read empty
    chk("R6 empty stays empty", int'(emptyFlag), 1);

    // Simultaneous push and read (R12)
    for (int i = 0; i < 3; i++) step(1, 1, 'h0a0 + i, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 1, 'h1b0 + i, 0, 1, 0);
    n = 0;
    while (!emptyFlag && n < 20) begin
      step(1, 0, 0, 0, 1, 0);
      n++;
    end
    chk("R12 entries held after mixed cycles", n, 3);

    // Break entry (R8)
    step(1, 1, 'h0ff, 1, 0, 0);
    chk("R8 break entry", int'(rdEntry), 'h400);
    step(1, 0, 0, 0, 1, 0);
    chk("R8 break status bit", int'(rxStatus), 4);

    // Clear wins over read (R7)
    step(1, 1, 'ha55, 0, 0, 0);
    step(1, 0, 0, 0, 1, 1);
    chk("R7 clear wins", int'(rxStatus), 0);

    // Flush with backlog and a read in the same cycle (R11)
    step(1, 1, 'h311, 0, 0, 0);
    step(1, 1, 'h822, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    chk("R11 flushed empty", int'(emptyFlag), 1);
    chk("R11 status untouched by ignored read", int'(rxStatus), 0);
    chk("R11 accepts after flush", int'(canAccept), 1);

    // Random phase
    begin
      bit en = 0;
      for (int i = 0; i < 1500; i++) begin
        if ($urandom % 60 == 0) en = !en;
        step(en, ($urandom % 2) == 1, int'($urandom % 4096), ($urandom % 20) == 0,
             ($urandom % 5) < 2, ($urandom % 15) == 0);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule